// File: doc/BRIEF.md
# Multi-Mode Pulse Timer with Capture

This block is a general-purpose timer with one external pin and a single counter. The counter is shared by three functions. It can generate a pulse-width waveform on the pin, count rising edges that arrive on the pin, or measure the high time and the repetition time of a signal driven onto the pin. In the generating and measuring functions, the counter advances on a selectable source: the system clock or either of two external clock inputs. Every external input is resynchronised before use.

Software programs the block through a small register port. It writes a control word, a period and a width, then sets the enable bit. In capture mode the period and width registers are overwritten by the measured values, so software reads the results from the same locations. A measurement of this kind can find the bit time of an incoming serial stream. A single pending flag drives the interrupt output. The flag is set when a period completes or when a width measurement finishes. A second sticky flag records that the capture counter ran to all ones.

Top module: `gptmr_top`

## Requirements
- R1: While reset is held, `pin_out`, `pin_oe` and `irq` are low and every register reads as zero.
- R2: The register addresses are: 0 = control, 1 = period, 2 = width, 3 = status. Control bit 0 is enable. Control bits 2:1 select the mode: 0 PWM, 1 edge count, 2 capture, 3 idle. Control bits 4:3 select the source: 0 system clock, 1 external A, 2 external B, 3 none. Status bit 0 is pending and bit 1 is overflow. Reads return the stored values, zero-extended. Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear.
- R3: In enabled PWM mode, the counter steps from 0 to period-1 once per tick and then wraps. `pin_oe` is high, and `pin_out` is high while the count is below the width. In every other state `pin_oe` is low.
- R4: A width of 0 keeps `pin_out` constantly low.
- R5: A nonzero width at or above the period keeps `pin_out` constantly high.
- R6: In PWM and edge-count modes, each counter wrap sets pending. `irq` equals pending.
- R7: With an external source, each rising edge of the selected input advances the counter exactly once, three clock edges after it arrives. The unselected input has no effect, and source 3 never advances the counter.
- R8: In edge-count mode, the counter advances on rising edges of the pin, whatever source is selected, and wraps at the period as in R6.
- R9: In capture mode, a pin rising edge loads the running count into the period register. The counter restarts at 1 if a tick coincides with the edge, and at 0 otherwise.
- R10: In capture mode, a pin falling edge loads the running count into the width register and sets pending.
- R11: In capture mode, a tick that finds the counter at all ones leaves it at all ones and sets the overflow flag.
- R12: When the block is disabled or in idle mode, the counter is held at zero, the pin is not driven and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` (combinational) |
| pin_in | input | 1 | External pin level (asynchronous) |
| pin_out | output | 1 | Waveform driven onto the pin |
| pin_oe | output | 1 | Output enable for the pin |
| ext_clk_a | input | 1 | External count source A (asynchronous) |
| ext_clk_b | input | 1 | External count source B (asynchronous) |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
The bench builds the block with an 8-bit counter (CW = 8). At that width, the counter reaches all ones after 255 system-clock ticks, so the overflow flag and the saturated period capture can be reached in a few hundred cycles. At the 32-bit default they would be out of reach. The small width also keeps the wrap arithmetic, and the comparisons of width against period, close to their edges. PWM periods of 4 and 5 and capture pulses of 4 high and 6 low cycles then show every wrap, every edge-to-count latency and every capture within short runs.

// File: rtl/gptmr_pkg.sv
package gptmr_pkg;

  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_EVT  = 2'd1,
    MODE_CAP  = 2'd2,
    MODE_IDLE = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_EXTA = 2'd1,
    SRC_EXTB = 2'd2,
    SRC_NONE = 2'd3
  } tmr_src_e;

  // control word: src in bits 4:3, mode in 2:1, enable in 0
  typedef struct packed {
    tmr_src_e  src;
    tmr_mode_e mode;
    logic      en;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_WIDTH  = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

endpackage

// File: rtl/gptmr_sync.sv
module gptmr_sync #(
  parameter int LANES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_in,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);
  localparam int SH_W = STAGES + 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SH_W-2:0], async_in[i]};
    end
    assign rise[i] =  sh[STAGES-1] & ~sh[STAGES];
    assign fall[i] = ~sh[STAGES-1] &  sh[STAGES];
  end
endmodule

// File: rtl/gptmr_counter.sv
module gptmr_counter
  import gptmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_ctrl_t     ctrl,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] width,
  input  logic          tick,
  input  logic          pin_rise,
  input  logic          pin_fall,
  output logic [CW-1:0] cnt,
  output logic          active,
  output logic          period_evt,
  output logic          cap_rise_evt,
  output logic          cap_fall_evt,
  output logic          ovf_evt,
  output logic          pwm_level
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // wrap when the next count would reach the period (period 0 acts as 1)
  function automatic logic wrap_due(input logic [CW-1:0] c, input logic [CW-1:0] p);
    return ({1'b0, c} + 1'b1) >= {1'b0, p};
  endfunction

  function automatic logic level_high(input logic [CW-1:0] c, input logic [CW-1:0] w);
    return c < w;
  endfunction

  logic run, cap, step, at_max;

  assign active = ctrl.en && (ctrl.mode != MODE_IDLE);
  assign run    = active && (ctrl.mode == MODE_PWM || ctrl.mode == MODE_EVT);
  assign cap    = active && (ctrl.mode == MODE_CAP);
  assign step   = (ctrl.mode == MODE_EVT) ? pin_rise : tick;
  assign at_max = (cnt == CNT_MAX);

  assign period_evt   = run && step && wrap_due(cnt, period);
  assign cap_rise_evt = cap && pin_rise;
  assign cap_fall_evt = cap && pin_fall;
  assign ovf_evt      = cap && !pin_rise && tick && at_max;
  assign pwm_level    = level_high(cnt, width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (run) begin
      if (step) cnt <= wrap_due(cnt, period) ? '0 : cnt + 1'b1;
    end else if (pin_rise) begin
      cnt <= CW'(tick);
    end else if (tick && !at_max) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gptmr_regs.sv
module gptmr_regs
  import gptmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  input  logic          period_evt,
  input  logic          cap_rise_evt,
  input  logic          cap_fall_evt,
  input  logic          ovf_evt,
  output tmr_ctrl_t     ctrl,
  output logic [CW-1:0] period,
  output logic [CW-1:0] width,
  output logic          pend,
  output logic          ovf_flag,
  output logic [CW-1:0] rdata
);
  logic wr_ctrl, wr_per, wr_wid, wr_stat;

  assign wr_ctrl = wr && (addr == ADDR_CTRL);
  assign wr_per  = wr && (addr == ADDR_PERIOD);
  assign wr_wid  = wr && (addr == ADDR_WIDTH);
  assign wr_stat = wr && (addr == ADDR_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      period   <= '0;
      width    <= '0;
      pend     <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
      if (cap_rise_evt)  period <= cnt;
      else if (wr_per)   period <= wdata;
      if (cap_fall_evt)  width <= cnt;
      else if (wr_wid)   width <= wdata;
      pend     <= (pend     & ~(wr_stat & wdata[0])) | period_evt | cap_fall_evt;
      ovf_flag <= (ovf_flag & ~(wr_stat & wdata[1])) | ovf_evt;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdata = {{(CW-CTRL_W){1'b0}}, ctrl};
      ADDR_PERIOD: rdata = period;
      ADDR_WIDTH:  rdata = width;
      default:     rdata = {{(CW-2){1'b0}}, ovf_flag, pend};
    endcase
  end
endmodule

// File: rtl/gptmr_top.sv
module gptmr_top
  import gptmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  input  logic          ext_clk_a,
  input  logic          ext_clk_b,
  output logic          irq
);
  localparam int LANES = 3;

  logic [LANES-1:0] rise_v, fall_v;
  logic             pin_rise, pin_fall, tick;
  logic [CW-1:0]    cnt, period, width;
  logic             active, period_evt, cap_rise_evt, cap_fall_evt, ovf_evt;
  logic             pwm_level, pend, ovf_flag;
  tmr_ctrl_t        ctrl;
  logic             unused_ext_fall;

  gptmr_sync #(.LANES(LANES), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ext_clk_b, ext_clk_a, pin_in}),
    .rise     (rise_v),
    .fall     (fall_v)
  );

  assign pin_rise        = rise_v[0];
  assign pin_fall        = fall_v[0];
  assign unused_ext_fall = ^fall_v[LANES-1:1];

  always_comb begin
    case (ctrl.src)
      SRC_SYS:  tick = 1'b1;
      SRC_EXTA: tick = rise_v[1];
      SRC_EXTB: tick = rise_v[2];
      default:  tick = 1'b0;
    endcase
  end

  gptmr_counter #(.CW(CW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .period       (period),
    .width        (width),
    .tick         (tick),
    .pin_rise     (pin_rise),
    .pin_fall     (pin_fall),
    .cnt          (cnt),
    .active       (active),
    .period_evt   (period_evt),
    .cap_rise_evt (cap_rise_evt),
    .cap_fall_evt (cap_fall_evt),
    .ovf_evt      (ovf_evt),
    .pwm_level    (pwm_level)
  );

  gptmr_regs #(.CW(CW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .cnt          (cnt),
    .period_evt   (period_evt),
    .cap_rise_evt (cap_rise_evt),
    .cap_fall_evt (cap_fall_evt),
    .ovf_evt      (ovf_evt),
    .ctrl         (ctrl),
    .period       (period),
    .width        (width),
    .pend         (pend),
    .ovf_flag     (ovf_flag),
    .rdata        (reg_rdata)
  );

  assign pin_oe  = ctrl.en && (ctrl.mode == MODE_PWM);
  assign pin_out = pin_oe && pwm_level;
  assign irq     = pend;
endmodule

// File: rtl/gptmr_chk.sv
module gptmr_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] period,
  input logic [CW-1:0] width,
  input logic          active,
  input logic          period_evt,
  input logic          cap_rise_evt,
  input logic          cap_fall_evt,
  input logic          ovf_evt,
  input logic          ovf_flag
);
  // R3
  oe_gates_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> pin_oe);

  // R4
  width_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && width == '0) |-> !pin_out);

  // R5
  width_full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && width != '0 && width >= period && cnt < period) |-> pin_out);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(period_evt || cap_fall_evt));

  // R9
  cap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise_evt |=> (cnt <= CW'(1)));

  // R10
  cap_width_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fall_evt |=> irq);

  // R11
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (ovf_flag && $stable(cnt)));

  // R12
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

bind gptmr_top gptmr_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .irq          (irq),
  .cnt          (cnt),
  .period       (period),
  .width        (width),
  .active       (active),
  .period_evt   (period_evt),
  .cap_rise_evt (cap_rise_evt),
  .cap_fall_evt (cap_fall_evt),
  .ovf_evt      (ovf_evt),
  .ovf_flag     (ovf_flag)
);

// File: tb/sim_gptmr_top.sv
`timescale 1ns/1ps
module sim_gptmr_top;
  localparam int CW  = 8;
  localparam int MAXC = (1 << CW) - 1;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          pin_in = 1'b0;
  logic          pin_out, pin_oe, irq;
  logic          ext_clk_a = 1'b0;
  logic          ext_clk_b = 1'b0;

  gptmr_top #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ext_clk_a(ext_clk_a),
    .ext_clk_b(ext_clk_b), .irq(irq)
  );

  always #2 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    started = 0;
  string phase = "R1";

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // behavioural reference model
  int m_ctrl, m_per, m_wid, m_cnt;
  bit m_pend, m_ovf;
  bit qp[$], qa[$], qb[$];

  function automatic int m_read(int a);
    case (a)
      0: return m_ctrl;
      1: return m_per;
      2: return m_wid;
      default: return (int'(m_ovf) << 1) | int'(m_pend);
    endcase
  endfunction

  function automatic bit m_oe();
    return (m_ctrl & 1) != 0 && ((m_ctrl >> 1) & 3) == 0;
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_per = 0; m_wid = 0; m_cnt = 0; m_pend = 0; m_ovf = 0;
    qp = '{0, 0, 0}; qa = '{0, 0, 0}; qb = '{0, 0, 0};
  endtask

  task automatic model_step();
    bit pr, pf, ar, br, tk, en, setp, seto;
    int mode, src, nc, np, nw;
    pr = qp[1] && !qp[2];  pf = !qp[1] && qp[2];
    ar = qa[1] && !qa[2];  br = qb[1] && !qb[2];
    en = (m_ctrl & 1) != 0; mode = (m_ctrl >> 1) & 3; src = (m_ctrl >> 3) & 3;
    tk = (src == 0) ? 1'b1 : (src == 1) ? ar : (src == 2) ? br : 1'b0;
    nc = m_cnt; np = m_per; nw = m_wid; setp = 0; seto = 0;
    if (reg_wr && reg_addr == 1) np = int'(reg_wdata);
    if (reg_wr && reg_addr == 2) nw = int'(reg_wdata);
    if (!en || mode == 3) nc = 0;
    else if (mode < 2) begin
      bit st;
      st = (mode == 1) ? pr : tk;
      if (st) begin
        if (m_cnt + 1 >= m_per) begin nc = 0; setp = 1; end
        else nc = m_cnt + 1;
      end
    end else begin
      if (pr) begin np = m_cnt; nc = tk ? 1 : 0; end
      else if (tk) begin
        if (m_cnt == MAXC) seto = 1; else nc = m_cnt + 1;
      end
      if (pf) begin nw = m_cnt; setp = 1; end
    end
    m_pend = (m_pend && !(reg_wr && reg_addr == 3 && reg_wdata[0])) || setp;
    m_ovf  = (m_ovf  && !(reg_wr && reg_addr == 3 && reg_wdata[1])) || seto;
    if (reg_wr && reg_addr == 0) m_ctrl = int'(reg_wdata) & 31;
    m_cnt = nc; m_per = np; m_wid = nw;
    qp.push_front(pin_in);    void'(qp.pop_back());
    qa.push_front(ext_clk_a); void'(qa.pop_back());
    qb.push_front(ext_clk_b); void'(qb.pop_back());
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      bit eo;
      eo = m_oe();
      chk(pin_oe == eo, phase, "pin_oe", pin_oe, eo);
      chk(pin_out == (eo && m_cnt < m_wid), phase, "pin_out", pin_out, eo && m_cnt < m_wid);
      chk(irq == m_pend, phase, "irq", irq, m_pend);
      chk(int'(reg_rdata) == m_read(int'(reg_addr)), phase, "reg_rdata",
          reg_rdata, m_read(int'(reg_addr)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      chk(0, "watchdog", "cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = CW'(d);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(int a, int expv, string req);
    reg_addr = 2'(a);
    @(negedge clk);
    chk(int'(reg_rdata) == expv, req, "register read", reg_rdata, expv);
    @(posedge clk); #1;
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out) h++;
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_a(int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_a = 1'b1; wait_n(2); ext_clk_a = 1'b0; wait_n(2);
    end
  endtask

  task automatic pulse_pin(int n);
    for (int i = 0; i < n; i++) begin
      pin_in = 1'b1; wait_n(2); pin_in = 1'b0; wait_n(2);
    end
  endtask

  initial begin
    int h;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(pin_out == 1'b0, "R1", "pin_out", pin_out, 0);
    chk(pin_oe == 1'b0, "R1", "pin_oe", pin_oe, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #0.2;
      chk(reg_rdata == '0, "R1", "reset read", reg_rdata, 0);
    end
    reg_addr = '0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    started = 1;

    // R2: register map and write-one-to-clear
    phase = "R2";
    wr(1, 5); wr(2, 2);
    rd_chk(1, 5, "R2"); rd_chk(2, 2, "R2");
    wr(0, 8'h08); rd_chk(0, 8'h08, "R2"); wr(0, 0);

    // R3 / R6: PWM on the system clock, period 5 width 2
    phase = "R3";
    wr(0, 1);
    wait_n(7);
    count_high(10, h);
    chk(h == 4, "R3", "high cycles in 10", h, 4);
    chk(irq == 1'b1, "R6", "irq after wraps", irq, 1);
    wr(0, 0); wr(3, 3);
    rd_chk(3, 0, "R2");

    // R4: width zero
    phase = "R4";
    wr(2, 0); wr(0, 1);
    count_high(12, h);
    chk(h == 0, "R4", "high cycles", h, 0);
    wr(0, 0);

    // R5: width above period
    phase = "R5";
    wr(2, 7); wr(0, 1);
    count_high(12, h);
    chk(h == 12, "R5", "high cycles", h, 12);
    wr(0, 0); wr(3, 1);

    // R7: external source A, period 4
    phase = "R7";
    wr(1, 4); wr(2, 2); wr(0, 1 | (1 << 3));
    pulse_a(3); wait_n(4);
    chk(irq == 1'b0, "R7", "irq after 3 edges", irq, 0);
    pulse_a(1); wait_n(4);
    chk(irq == 1'b1, "R7", "irq after 4 edges", irq, 1);
    wr(0, 0); wr(3, 1);
    wr(0, 1 | (2 << 3));
    pulse_a(8); wait_n(4);
    chk(irq == 1'b0, "R7", "unselected source ignored", irq, 0);
    wr(0, 0); wr(3, 1);
    wr(0, 1 | (3 << 3));
    ext_clk_b = 1'b1; wait_n(3); ext_clk_b = 1'b0;
    wait_n(20);
    chk(irq == 1'b0, "R7", "no source never wraps", irq, 0);
    wr(0, 0); wr(3, 1);

    // R8: edge-count mode, system clock selected but not used
    phase = "R8";
    wr(0, 1 | (1 << 1));
    pulse_pin(3); wait_n(10);
    chk(irq == 1'b0, "R8", "irq after 3 pin edges", irq, 0);
    pulse_pin(1); wait_n(4);
    chk(irq == 1'b1, "R8", "irq after 4 pin edges", irq, 1);
    wr(0, 0); wr(3, 1);

    // R9 / R10: capture on the system clock, 4 high, 6 low
    phase = "R9";
    wr(0, 1 | (2 << 1));
    for (int i = 0; i < 5; i++) begin
      pin_in = 1'b1; wait_n(4); pin_in = 1'b0; wait_n(6);
    end
    wait_n(3);
    rd_chk(1, 10, "R9");
    rd_chk(2, 4, "R10");
    chk(irq == 1'b1, "R10", "irq after width capture", irq, 1);

    // R11: overflow with the pin held low
    phase = "R11";
    wait_n(300);
    rd_chk(3, 3, "R11");
    pin_in = 1'b1; wait_n(5);
    rd_chk(1, MAXC, "R11");
    pin_in = 1'b0; wait_n(5);
    wr(3, 3);

    // R12: idle mode, pin activity raises nothing
    phase = "R12";
    wr(1, 4); wr(2, 2);
    wr(0, 1 | (3 << 1));
    pulse_pin(6);
    @(negedge clk);
    chk(pin_oe == 1'b0, "R12", "pin_oe idle", pin_oe, 0);
    chk(irq == 1'b0, "R12", "irq idle", irq, 0);
    @(posedge clk); #1;
    wr(0, 0);
    wait_n(3);

    started = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule